// File: doc/BRIEF.md
# Grouped-Priority Channel Allocator

This block hands out physical transfer channels from a shared pool. A requester raises a request together with the number of the peripheral request line it serves. One cycle later the allocator answers with either a granted channel index or a no-channel pulse. When a channel is granted, the allocator also emits a write to an external binding table. That write ties the request line to the channel and sets a valid flag.

Channels are ranked in four priority levels, taken from bits 3:2 of the channel index. Level 0 holds channels 0–3 and 16–19, level 1 holds 4–7 and 20–23, and so on. The search covers level 0 first and moves upward. Within a level the lowest free index wins. How many levels are searched depends on the channel count. A release strobe returns a channel to the pool and clears the binding-table entry of the line that channel was granted for. A release and a request in the same cycle are processed release first.

Top module: `chan_alloc`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busyMask` is all zero and `grantValid`, `grantNone`, `mapSetEn` and `mapClrEn` are 0.
- R2: A request sampled at a clock edge produces its answer (`grantValid` or `grantNone`, a one-cycle pulse) in the cycle that follows. A granted channel shows as set in `busyMask` in that same cycle.
- R3: The priority level of channel i is (i mod 16) div 4, that is, index bits 3:2, with level 0 highest. The granted channel is the lowest free index in the lowest-numbered level that still has a free channel.
- R4: Only levels 0 through ((CHAN_COUNT-1) mod 16) div 4 are searched. With 20 channels only channels 0–3 and 16–19 can ever be granted.
- R5: A request that finds no free channel pulses `grantNone`. It changes no busy bit and issues no binding write.
- R6: A grant pulses `mapSetEn` with `mapSetLine` equal to the requesting line. `mapSetData` then has bit 7 = 1 (valid), bits 6:5 = 0 and bits 4:0 = the granted channel.
- R7: Releasing a busy channel clears its busy bit. It also pulses `mapClrEn` one cycle later, with `mapClrLine` equal to the line that channel was last granted for (the entry is to be written to zero).
- R8: Releasing a channel that is not busy has no effect: no `mapClrEn` pulse and no change to `busyMask`.
- R9: When a release and a request arrive in the same cycle, the release is applied first. The freed channel then competes in that same search and is granted if it ranks highest among the free channels.
- R10: `busyMask` bit i is 1 exactly while channel i is held. It changes only through grants and releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request a channel this cycle |
| reqLine | input | LINE_W | Peripheral request line to bind |
| relValid | input | 1 | Release a channel this cycle |
| relChan | input | 5 | Channel to release |
| grantValid | output | 1 | Grant pulse |
| grantNone | output | 1 | No channel was free |
| grantChan | output | 5 | Granted channel index |
| mapSetEn | output | 1 | Binding-table write (set) |
| mapSetLine | output | LINE_W | Line whose entry is set |
| mapSetData | output | 8 | Entry value: valid bit 7, channel in bits 4:0 |
| mapClrEn | output | 1 | Binding-table write (clear to zero) |
| mapClrLine | output | LINE_W | Line whose entry is cleared |
| busyMask | output | CHAN_COUNT | Channels currently held |

## Verification
The bench drains a full 32-channel pool and checks the interleaved grant order 0–3, 16–19, 4–7 and so on. A design that ranked by plain index, or by bit 4, would hand out channel 4 fifth. It also frees channels from three different levels and confirms they come back by level and not by index. It issues a same-cycle release and request, where a grant-first design would report no channel or pick the wrong one. It releases an already-free channel, where a careless design emits a spurious binding clear. A second instance built with 20 channels checks that the level limit stops the search after level 0. A design that searched every level would grant channel 4 there instead of reporting no channel.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  localparam int IDX_W = 5;          // channel index width, up to 32 channels
  localparam int MAP_W = 8;          // binding entry width
  localparam int NUM_LVL = 4;        // priority levels from index bits 3:2

  typedef struct packed {
    logic             grantEn;
    logic             noneEn;
    logic             relEn;
    logic [IDX_W-1:0] grantIdx;
    logic [IDX_W-1:0] relIdx;
  } alloc_strb_t;
endpackage

// File: rtl/chan_search.sv
module chan_search
  import alloc_pkg::*;
#(
  parameter int CHAN_COUNT = 32
) (
  input  logic [CHAN_COUNT-1:0] freeMask,
  output logic                  hit,
  output logic [IDX_W-1:0]      idx
);
  localparam int MAX_LVL = ((CHAN_COUNT - 1) % 16) / 4;

  function automatic logic [CHAN_COUNT-1:0] levelMask(input int lvl);
    logic [CHAN_COUNT-1:0] m;
    for (int i = 0; i < CHAN_COUNT; i++) m[i] = (((i % 16) / 4) == lvl);
    return m;
  endfunction

  logic [NUM_LVL-1:0] lvlHit;
  logic [IDX_W-1:0]   lvlIdx [NUM_LVL];

  for (genvar g = 0; g < NUM_LVL; g++) begin : gLvl
    logic [CHAN_COUNT-1:0] lvlFree;
    logic [IDX_W-1:0]      lowIdx;
    if (g <= MAX_LVL) begin : gOn
      assign lvlFree = freeMask & levelMask(g);
    end else begin : gOff
      assign lvlFree = '0;
    end
    always_comb begin
      lowIdx = '0;
      for (int i = CHAN_COUNT - 1; i >= 0; i--) begin
        if (lvlFree[i]) lowIdx = IDX_W'(i);
      end
    end
    assign lvlHit[g] = |lvlFree;
    assign lvlIdx[g] = lowIdx;
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (lvlHit[l]) begin
        hit = 1'b1;
        idx = lvlIdx[l];
      end
    end
  end
endmodule

// File: rtl/alloc_ctrl.sv
module alloc_ctrl
  import alloc_pkg::*;
#(
  parameter int CHAN_COUNT = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  relValid,
  input  logic [IDX_W-1:0]      relChan,
  input  logic [CHAN_COUNT-1:0] busy,
  output alloc_strb_t           strb
);
  logic [CHAN_COUNT-1:0] relHot;
  logic [CHAN_COUNT-1:0] freeMask;
  logic                  relOk;
  logic                  found;
  logic [IDX_W-1:0]      foundIdx;

  // out-of-range channel numbers shift to zero and are ignored
  assign relHot   = CHAN_COUNT'(1) << relChan;
  assign relOk    = relValid && |(busy & relHot);
  // release is applied before the search
  assign freeMask = ~busy | (relOk ? relHot : '0);

  chan_search #(.CHAN_COUNT(CHAN_COUNT)) u_search (
    .freeMask (freeMask),
    .hit      (found),
    .idx      (foundIdx)
  );

  always_comb begin
    strb          = '0;
    strb.relEn    = relOk;
    strb.relIdx   = relChan;
    strb.grantEn  = reqValid && found;
    strb.noneEn   = reqValid && !found;
    strb.grantIdx = foundIdx;
  end

  AST_GRANT_IS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    strb.grantEn |-> (!busy[strb.grantIdx] || (strb.relEn && strb.relIdx == strb.grantIdx))); // R3
  AST_NONE_TOP_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (strb.noneEn && !strb.relEn) |-> (&busy[3:0])); // R5
endmodule

// File: rtl/alloc_datapath.sv
module alloc_datapath
  import alloc_pkg::*;
#(
  parameter int CHAN_COUNT = 32,
  parameter int LINE_W     = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  alloc_strb_t           strb,
  input  logic [LINE_W-1:0]     reqLine,
  output logic [CHAN_COUNT-1:0] busy,
  output logic                  grantValid,
  output logic                  grantNone,
  output logic [IDX_W-1:0]      grantChan,
  output logic                  mapSetEn,
  output logic [LINE_W-1:0]     mapSetLine,
  output logic [MAP_W-1:0]      mapSetData,
  output logic                  mapClrEn,
  output logic [LINE_W-1:0]     mapClrLine
);
  logic [LINE_W-1:0]     lineOf [CHAN_COUNT];
  logic [CHAN_COUNT-1:0] relHot;
  logic [CHAN_COUNT-1:0] grantHot;

  assign relHot   = strb.relEn   ? (CHAN_COUNT'(1) << strb.relIdx)   : '0;
  assign grantHot = strb.grantEn ? (CHAN_COUNT'(1) << strb.grantIdx) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= '0;
      grantValid <= 1'b0;
      grantNone  <= 1'b0;
      grantChan  <= '0;
      mapSetEn   <= 1'b0;
      mapSetLine <= '0;
      mapClrEn   <= 1'b0;
      mapClrLine <= '0;
      for (int i = 0; i < CHAN_COUNT; i++) lineOf[i] <= '0;
    end else begin
      grantValid <= strb.grantEn;
      grantNone  <= strb.noneEn;
      mapSetEn   <= strb.grantEn;
      mapClrEn   <= strb.relEn;
      if (strb.relEn) mapClrLine <= lineOf[strb.relIdx];
      if (strb.grantEn) begin
        grantChan              <= strb.grantIdx;
        mapSetLine             <= reqLine;
        lineOf[strb.grantIdx]  <= reqLine;
      end
      busy <= (busy & ~relHot) | grantHot;
    end
  end

  assign mapSetData = {1'b1, 2'b00, grantChan};

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> busy[grantChan]); // R2
  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rstN)
    !(grantValid && grantNone)); // R2
  AST_NONE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.noneEn && !strb.relEn) |=> ($stable(busy) && !mapSetEn)); // R5
  AST_MAP_FORMAT: assert property (@(posedge clk) disable iff (!rstN)
    mapSetEn |-> (mapSetData[7] && mapSetData[6:5] == 2'b00 && mapSetData[4:0] == grantChan)); // R6
  AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.relEn && !(strb.grantEn && strb.grantIdx == strb.relIdx)) |=> !busy[$past(strb.relIdx)]); // R7
endmodule

// File: rtl/chan_alloc.sv
module chan_alloc
  import alloc_pkg::*;
#(
  parameter int CHAN_COUNT = 32,
  parameter int LINE_COUNT = 64,
  localparam int LINE_W    = $clog2(LINE_COUNT)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [LINE_W-1:0]     reqLine,
  input  logic                  relValid,
  input  logic [IDX_W-1:0]      relChan,
  output logic                  grantValid,
  output logic                  grantNone,
  output logic [IDX_W-1:0]      grantChan,
  output logic                  mapSetEn,
  output logic [LINE_W-1:0]     mapSetLine,
  output logic [MAP_W-1:0]      mapSetData,
  output logic                  mapClrEn,
  output logic [LINE_W-1:0]     mapClrLine,
  output logic [CHAN_COUNT-1:0] busyMask
);
  alloc_strb_t           strb;
  logic [CHAN_COUNT-1:0] busy;

  alloc_ctrl #(.CHAN_COUNT(CHAN_COUNT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .relValid (relValid),
    .relChan  (relChan),
    .busy     (busy),
    .strb     (strb)
  );

  alloc_datapath #(.CHAN_COUNT(CHAN_COUNT), .LINE_W(LINE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqLine    (reqLine),
    .busy       (busy),
    .grantValid (grantValid),
    .grantNone  (grantNone),
    .grantChan  (grantChan),
    .mapSetEn   (mapSetEn),
    .mapSetLine (mapSetLine),
    .mapSetData (mapSetData),
    .mapClrEn   (mapClrEn),
    .mapClrLine (mapClrLine)
  );

  assign busyMask = busy;
endmodule

// File: tb/chan_alloc_bench.sv
`timescale 1ns/1ps
module chan_alloc_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, relValid = 1'b0;
  logic [5:0]  reqLine = '0;
  logic [4:0]  relChan = '0;
  logic        grantValid, grantNone, mapSetEn, mapClrEn;
  logic [4:0]  grantChan;
  logic [5:0]  mapSetLine, mapClrLine;
  logic [7:0]  mapSetData;
  logic [31:0] busyMask;

  chan_alloc u_chan_alloc (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLine(reqLine),
    .relValid(relValid), .relChan(relChan), .grantValid(grantValid),
    .grantNone(grantNone), .grantChan(grantChan), .mapSetEn(mapSetEn),
    .mapSetLine(mapSetLine), .mapSetData(mapSetData), .mapClrEn(mapClrEn),
    .mapClrLine(mapClrLine), .busyMask(busyMask)
  );

  // 20-channel variant for the level limit
  logic        sReq = 1'b0;
  logic        sGv, sGn, sSetEn, sClrEn;
  logic [4:0]  sCh;
  logic [5:0]  sSetLine, sClrLine;
  logic [7:0]  sSetData;
  logic [19:0] sBusy;

  chan_alloc #(.CHAN_COUNT(20)) u_chan_alloc_small (
    .clk(clk), .rstN(rstN), .reqValid(sReq), .reqLine(6'd1),
    .relValid(1'b0), .relChan(5'd0), .grantValid(sGv),
    .grantNone(sGn), .grantChan(sCh), .mapSetEn(sSetEn),
    .mapSetLine(sSetLine), .mapSetData(sSetData), .mapClrEn(sClrEn),
    .mapClrLine(sClrLine), .busyMask(sBusy)
  );

  typedef struct {
    bit gv; bit gn; int ch; bit setEn; int setLine;
    bit clrEn; int clrLine; logic [31:0] busy; string tag;
  } exp_t;

  exp_t        q[$];
  int          checks = 0, fails = 0;
  bit [31:0]   mBusy = '0;
  int          mLine [32];
  bit          done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // model: level = index bits 3:2, levels 0..3 searched, lowest index in level
  function automatic int pick(input bit [31:0] b);
    for (int lvl = 0; lvl < 4; lvl++)
      for (int i = 0; i < 32; i++)
        if (((i % 16) / 4) == lvl && !b[i]) return i;
    return -1;
  endfunction

  task automatic cycle(input bit rq, input int line, input bit rl, input int ch, input string tag);
    exp_t e;
    int   g;
    @(negedge clk);
    reqValid = rq; reqLine = 6'(line); relValid = rl; relChan = 5'(ch);
    e.gv = 0; e.gn = 0; e.ch = 0; e.setEn = 0; e.setLine = 0;
    e.clrEn = 0; e.clrLine = 0; e.tag = tag;
    if (rl && mBusy[ch]) begin
      e.clrEn = 1; e.clrLine = mLine[ch]; mBusy[ch] = 1'b0;
    end
    if (rq) begin
      g = pick(mBusy);
      if (g >= 0) begin
        e.gv = 1; e.ch = g; e.setEn = 1; e.setLine = line;
        mBusy[g] = 1'b1; mLine[g] = line;
      end else begin
        e.gn = 1;
      end
    end
    e.busy = mBusy;
    q.push_back(e);
  endtask

  // monitor: one expected item per cycle, compared after the capturing edge
  always @(posedge clk) begin
    exp_t e;
    bit   ok;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      ok = (grantValid == e.gv) && (grantNone == e.gn) &&
           (!e.gv || int'(grantChan) == e.ch) &&
           (mapSetEn == e.setEn) &&
           (!e.setEn || (int'(mapSetLine) == e.setLine &&
                         mapSetData == (8'h80 | 8'(e.ch)))) &&
           (mapClrEn == e.clrEn) && (!e.clrEn || int'(mapClrLine) == e.clrLine) &&
           (busyMask == e.busy);
      checks++;
      if (!ok) begin
        fails++;
        $display("FAIL %s: actual gv=%0d gn=%0d ch=%0d set=%0d/%0d/%h clr=%0d/%0d busy=%h expected gv=%0d gn=%0d ch=%0d set=%0d/%0d clr=%0d/%0d busy=%h",
                 e.tag, grantValid, grantNone, grantChan, mapSetEn, mapSetLine, mapSetData,
                 mapClrEn, mapClrLine, busyMask, e.gv, e.gn, e.ch, e.setEn, e.setLine,
                 e.clrEn, e.clrLine, e.busy);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(busyMask == 0 && !grantValid && !grantNone && !mapSetEn && !mapClrEn,
          "R1 in reset", int'(busyMask), 0);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #2;
    check(busyMask == 0 && !grantValid && !grantNone && !mapSetEn && !mapClrEn,
          "R1 after reset", int'(busyMask), 0);

    // drain the pool: interleaved level order, binding per line (R2 R3 R6 R10)
    for (int i = 0; i < 32; i++) cycle(1, i + 1, 0, 0, "R2/R3/R6/R10 drain");
    cycle(1, 40, 0, 0, "R5 pool empty");
    cycle(1, 41, 1, 5, "R9 release then grant same cycle");
    cycle(0, 0, 1, 17, "R7 release busy");
    cycle(0, 0, 1, 17, "R8 release of free channel");
    cycle(1, 42, 0, 0, "R3 refill");
    cycle(0, 0, 1, 30, "R7 release lvl3");
    cycle(0, 0, 1, 2, "R7 release lvl0");
    cycle(0, 0, 1, 9, "R7 release lvl2");
    cycle(1, 43, 0, 0, "R3 level0 first");
    cycle(1, 44, 0, 0, "R3 level2 next");
    cycle(1, 45, 0, 0, "R3 level3 last");
    cycle(1, 46, 0, 0, "R5 empty again");
    cycle(0, 0, 1, 28, "R7 release 28");
    cycle(1, 47, 1, 3, "R9 freed higher rank wins");
    cycle(1, 48, 0, 0, "R3 remaining 28");
    for (int i = 0; i < 3; i++) cycle(0, 0, 0, 0, "R10 idle hold");
    repeat (3) @(posedge clk);

    // 20 channels: only level 0 searched (R4)
    for (int k = 0; k < 9; k++) begin
      int expCh;
      expCh = (k < 4) ? k : k + 12;
      @(negedge clk) sReq = 1'b1;
      @(posedge clk); #2;
      if (k < 8)
        check(sGv && !sGn && int'(sCh) == expCh, "R4 small grant", int'(sCh), expCh);
      else
        check(!sGv && sGn, "R4 small none after level 0", int'(sGn), 1);
    end
    @(negedge clk) sReq = 1'b0;
    check(sBusy == 20'hF000F, "R4 small busy", int'(sBusy), 32'hF000F);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule